// File: doc/BRIEF.md
# Folded Symmetric FIR Filter

This block is a fixed-coefficient FIR filter with N taps whose impulse response is mirror-symmetric or mirror-antisymmetric. The two samples that meet the same coefficient are first combined, by addition in symmetric mode or by subtraction in antisymmetric mode. Only the half-set of coefficients is multiplied, so the datapath holds ceil(N/2) multipliers. The products then go through a pipelined binary adder tree. Every adder is followed by a register, so the clock rate depends on one adder or one multiplier, not on the whole sum.

The clock may run far faster than the sample rate. A one-cycle sample enable marks each new input sample. Every register in the block, from the delay line to the last tree stage, moves only on cycles where that enable is high. The result keeps full precision and cannot overflow. A valid flag marks the cycle in which a new result appears.

Top module: `fir_fold_sym`

## Requirements
- R1: In a clock cycle where `smp_en` is low, no filter register changes, so `y_out` keeps its value in the following cycle and `y_valid` is low.
- R2: The impulse response is defined by the packed parameter `COEFS`, which holds coefficient c[k] at bits [k*COEF_W +: COEF_W] for k = 0 .. ceil(N/2)-1. An isolated input sample of amplitude A produces, on successive valid outputs, A*h[0], A*h[1], ... A*h[N-1], followed by zeros.
- R3: In symmetric mode (`MODE` = FOLD_SYM), h[k] = h[N-1-k] = c[k], and the output equals the full convolution of the input with h.
- R4: In antisymmetric mode (`MODE` = FOLD_ANTI), h[k] = c[k] and h[N-1-k] = -c[k]. When N is odd, the centre tap's coefficient is zero whatever its `COEFS` field holds.
- R5: `y_out` is signed with width DATA_W + COEF_W + 1 + ceil(log2(ceil(N/2))). It is exact for any input sequence, including long runs at the most positive and the most negative input value.
- R6: The latency is LAT = 3 + ceil(log2(ceil(N/2))) enabled cycles. The result for the sample taken at the j-th enable after reset appears in the cycle after the (j+LAT-1)-th enable. `y_valid` is high in the cycle after each enable from the LAT-th enable after reset onward, and low in every other cycle.
- R7: A synchronous active-high `rst` clears the delay line, all pipeline registers, `y_out` and `y_valid` to zero. It also restarts the latency count, and `smp_en` is ignored while it is high.
- R8: Every input bit reaches the result: an impulse carrying only bit b of `smp_in` (bit DATA_W-1 being the sign, weight -2^(DATA_W-1)) produces exactly 2^b (or -2^(DATA_W-1)) times the coefficient sequence.
- R9: For even N there is no centre tap: all N/2 coefficients are paired, and the output is exact in symmetric mode.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous reset, active high |
| smp_en | input | 1 | One-cycle strobe that accepts `smp_in` and advances every register |
| smp_in | input | DATA_W | Signed input sample |
| y_out | output | DATA_W+COEF_W+1+ceil(log2(ceil(N/2))) | Signed full-precision filter output |
| y_valid | output | 1 | High for one cycle after each enable once the pipeline is full |

## Verification
The hardest condition to reach is the extreme of the arithmetic. Every mirrored pair and every product must sit at its worst-case magnitude at the same time, because only then can a missing guard bit in the pre-adder or the tree show up. Long runs of the most negative and then the most positive sample fill the whole delay line with one extreme, and the coefficients are chosen to include both -2^(COEF_W-1) and 2^(COEF_W-1)-1. A walking single bit covers each input wire separately. Irregular enable gaps, including back-to-back enables and a reset in mid-stream, check that nothing moves between samples.

// File: rtl/fir_fold_pkg.sv
package fir_fold_pkg;

   typedef enum logic {FOLD_SYM = 1'b0, FOLD_ANTI = 1'b1} fold_mode_e;

   function automatic int fold_half(input int n);
      return (n + 1) / 2;
   endfunction

   function automatic int fold_levels(input int n);
      return $clog2(fold_half(n));
   endfunction

   function automatic int fold_latency(input int n);
      return 3 + fold_levels(n);
   endfunction

endpackage

// File: rtl/fold_delay_line.sv
module fold_delay_line #(
   parameter int NTAPS  = 7,
   parameter int DATA_W = 12
) (
   input  logic                          clk,
   input  logic                          rst,
   input  logic                          en,
   input  logic [DATA_W-1:0]             din,
   output logic [NTAPS-1:0][DATA_W-1:0]  taps
);

   always_ff @(posedge clk) begin
      if (rst) begin
         taps <= '0;
      end else if (en) begin
         taps[0] <= din;
         for (int i = 1; i < NTAPS; i++) begin
            taps[i] <= taps[i-1];
         end
      end
   end

   // R1: the line shifts by exactly one position per enabled cycle
   p_shift_r1 : assert property (@(posedge clk) disable iff (rst)
      en |=> (taps[NTAPS-1] == $past(taps[NTAPS-2])));
   p_hold_line_r1 : assert property (@(posedge clk) disable iff (rst)
      !en |=> $stable(taps));

endmodule

// File: rtl/fold_preadd.sv
module fold_preadd
   import fir_fold_pkg::*;
#(
   parameter int         NTAPS  = 7,
   parameter int         DATA_W = 12,
   parameter fold_mode_e MODE   = FOLD_SYM,
   localparam int        NHALF  = fold_half(NTAPS),
   localparam int        NPAIR  = NTAPS / 2,
   localparam int        PRE_W  = DATA_W + 1
) (
   input  logic                          clk,
   input  logic                          rst,
   input  logic                          en,
   input  logic [NTAPS-1:0][DATA_W-1:0]  taps,
   output logic [NHALF-1:0][PRE_W-1:0]   pre_q
);

   for (genvar k = 0; k < NPAIR; k++) begin : g_pair
      logic signed [PRE_W-1:0] near_s, far_s, comb_s;
      assign near_s = PRE_W'($signed(taps[k]));
      assign far_s  = PRE_W'($signed(taps[NTAPS-1-k]));
      if (MODE == FOLD_ANTI) begin : g_sub
         assign comb_s = near_s - far_s;
      end else begin : g_add
         assign comb_s = near_s + far_s;
      end
      always_ff @(posedge clk) begin
         if (rst)     pre_q[k] <= '0;
         else if (en) pre_q[k] <= comb_s;
      end
   end

   if (NTAPS % 2 == 1) begin : g_centre
      always_ff @(posedge clk) begin
         if (rst)     pre_q[NHALF-1] <= '0;
         else if (en) pre_q[NHALF-1] <= PRE_W'($signed(taps[NHALF-1]));
      end
   end

endmodule

// File: rtl/fold_mult.sv
module fold_mult
   import fir_fold_pkg::*;
#(
   parameter int                        NTAPS  = 7,
   parameter int                        PRE_W  = 13,
   parameter int                        COEF_W = 10,
   parameter fold_mode_e                MODE   = FOLD_SYM,
   localparam int                       NHALF  = fold_half(NTAPS),
   parameter logic [NHALF*COEF_W-1:0]   COEFS  = '0,
   localparam int                       PROD_W = PRE_W + COEF_W
) (
   input  logic                          clk,
   input  logic                          rst,
   input  logic                          en,
   input  logic [NHALF-1:0][PRE_W-1:0]   pre,
   output logic [NHALF-1:0][PROD_W-1:0]  prod_q
);

   localparam bit ODD = (NTAPS % 2) == 1;

   for (genvar k = 0; k < NHALF; k++) begin : g_mul
      localparam bit ZERO_C = ODD && (MODE == FOLD_ANTI) && (k == NHALF - 1);
      localparam logic signed [COEF_W-1:0] CK =
         ZERO_C ? '0 : COEFS[k*COEF_W +: COEF_W];
      logic signed [PROD_W-1:0] p_s;
      assign p_s = PROD_W'($signed(pre[k])) * PROD_W'(CK);
      always_ff @(posedge clk) begin
         if (rst)     prod_q[k] <= '0;
         else if (en) prod_q[k] <= p_s;
      end
      // R3: a zero pre-combined pair can only give a zero product
      p_prod_zero_r3 : assert property (@(posedge clk) disable iff (rst)
         (en && pre[k] == '0) |=> (prod_q[k] == '0));
   end

endmodule

// File: rtl/fold_tree.sv
module fold_tree #(
   parameter int NLEAF = 4,
   parameter int IN_W  = 23,
   parameter int OUT_W = 25
) (
   input  logic                        clk,
   input  logic                        rst,
   input  logic                        en,
   input  logic [NLEAF-1:0][IN_W-1:0]  leaves,
   output logic [OUT_W-1:0]            sum
);

   localparam int LEVELS = $clog2(NLEAF);
   localparam int NP     = 1 << LEVELS;

   logic signed [OUT_W-1:0] leaf [NP];

   for (genvar j = 0; j < NP; j++) begin : g_leaf
      if (j < NLEAF) begin : g_real
         assign leaf[j] = OUT_W'($signed(leaves[j]));
      end else begin : g_pad
         assign leaf[j] = '0;
      end
   end

   if (LEVELS == 0) begin : g_flat
      assign sum = leaf[0];
   end else begin : g_heap
      logic signed [OUT_W-1:0] node_q [NP-1];
      for (genvar i = 0; i < NP - 1; i++) begin : g_node
         if (2*i + 1 >= NP - 1) begin : g_bottom
            always_ff @(posedge clk) begin
               if (rst)     node_q[i] <= '0;
               else if (en) node_q[i] <= leaf[2*i+1-(NP-1)] + leaf[2*i+2-(NP-1)];
            end
         end else begin : g_inner
            always_ff @(posedge clk) begin
               if (rst)     node_q[i] <= '0;
               else if (en) node_q[i] <= node_q[2*i+1] + node_q[2*i+2];
            end
         end
      end
      assign sum = node_q[0];
   end

endmodule

// File: rtl/fir_fold_sym.sv
module fir_fold_sym
   import fir_fold_pkg::*;
#(
   parameter int                                   NTAPS  = 7,
   parameter int                                   DATA_W = 12,
   parameter int                                   COEF_W = 10,
   parameter fold_mode_e                           MODE   = FOLD_SYM,
   parameter logic [((NTAPS+1)/2)*COEF_W-1:0]      COEFS  =
      {10'h2D4, 10'h04D, 10'h1FF, 10'h200},
   localparam int                                  NHALF  = fold_half(NTAPS),
   localparam int                                  ACC_W  = DATA_W + COEF_W + 1 + fold_levels(NTAPS)
) (
   input  logic                     clk,
   input  logic                     rst,
   input  logic                     smp_en,
   input  logic signed [DATA_W-1:0] smp_in,
   output logic signed [ACC_W-1:0]  y_out,
   output logic                     y_valid
);

   localparam int PRE_W  = DATA_W + 1;
   localparam int PROD_W = PRE_W + COEF_W;
   localparam int LAT    = fold_latency(NTAPS);
   localparam int CNT_W  = $clog2(LAT);

   if (NTAPS < 2) begin : g_bad_taps
      $error("fir_fold_sym: NTAPS must be at least 2");
   end
   if (DATA_W < 2 || COEF_W < 2) begin : g_bad_width
      $error("fir_fold_sym: DATA_W and COEF_W must be at least 2");
   end

   logic [NTAPS-1:0][DATA_W-1:0]  taps;
   logic [NHALF-1:0][PRE_W-1:0]   pre;
   logic [NHALF-1:0][PROD_W-1:0]  prod;
   logic [ACC_W-1:0]              sum;

   fold_delay_line #(.NTAPS(NTAPS), .DATA_W(DATA_W)) u_line (
      .clk(clk), .rst(rst), .en(smp_en), .din(smp_in), .taps(taps));

   fold_preadd #(.NTAPS(NTAPS), .DATA_W(DATA_W), .MODE(MODE)) u_pre (
      .clk(clk), .rst(rst), .en(smp_en), .taps(taps), .pre_q(pre));

   fold_mult #(.NTAPS(NTAPS), .PRE_W(PRE_W), .COEF_W(COEF_W), .MODE(MODE),
               .COEFS(COEFS)) u_mul (
      .clk(clk), .rst(rst), .en(smp_en), .pre(pre), .prod_q(prod));

   fold_tree #(.NLEAF(NHALF), .IN_W(PROD_W), .OUT_W(ACC_W)) u_tree (
      .clk(clk), .rst(rst), .en(smp_en), .leaves(prod), .sum(sum));

   assign y_out = $signed(sum);

   logic [CNT_W-1:0] fill_q;

   always_ff @(posedge clk) begin
      if (rst) begin
         fill_q  <= '0;
         y_valid <= 1'b0;
      end else begin
         y_valid <= smp_en && (fill_q == CNT_W'(LAT - 1));
         if (smp_en && fill_q != CNT_W'(LAT - 1)) fill_q <= fill_q + 1'b1;
      end
   end

   p_hold_r1 : assert property (@(posedge clk) disable iff (rst)
      !smp_en |=> ($stable(y_out) && !y_valid));
   p_valid_after_en_r6 : assert property (@(posedge clk) disable iff (rst)
      y_valid |-> $past(smp_en));
   p_reset_clear_r7 : assert property (@(posedge clk) disable iff (rst)
      $past(rst) |-> (y_out == '0 && !y_valid));

endmodule

// File: tb/fir_fold_sym_tb.sv
module fir_fold_sym_tb;
   import fir_fold_pkg::*;

   localparam int DATA_W = 12;
   localparam int COEF_W = 10;
   localparam logic [4*COEF_W-1:0] CPACK = {10'h2D4, 10'h04D, 10'h1FF, 10'h200};
   localparam int CV [4] = '{-512, 511, 77, -300};
   localparam int NT [3] = '{7, 7, 6};
   localparam int AN [3] = '{0, 1, 0};
   localparam int ACC7 = DATA_W + COEF_W + 1 + $clog2(4);
   localparam int ACC6 = DATA_W + COEF_W + 1 + $clog2(3);

   logic clk = 1'b0;
   logic rst = 1'b1;
   logic en  = 1'b0;
   logic signed [DATA_W-1:0] din = '0;
   logic signed [ACC7-1:0] y0, y1;
   logic signed [ACC6-1:0] y2;
   logic v0, v1, v2;

   always #4 clk = ~clk;

   fir_fold_sym #(.NTAPS(7), .DATA_W(DATA_W), .COEF_W(COEF_W), .MODE(FOLD_SYM),
                  .COEFS(CPACK)) u_dut (
      .clk(clk), .rst(rst), .smp_en(en), .smp_in(din), .y_out(y0), .y_valid(v0));
   fir_fold_sym #(.NTAPS(7), .DATA_W(DATA_W), .COEF_W(COEF_W), .MODE(FOLD_ANTI),
                  .COEFS(CPACK)) u_dut_anti (
      .clk(clk), .rst(rst), .smp_en(en), .smp_in(din), .y_out(y1), .y_valid(v1));
   fir_fold_sym #(.NTAPS(6), .DATA_W(DATA_W), .COEF_W(COEF_W), .MODE(FOLD_SYM),
                  .COEFS(CPACK[3*COEF_W-1:0])) u_dut_even (
      .clk(clk), .rst(rst), .smp_en(en), .smp_in(din), .y_out(y2), .y_valid(v2));

   int checks = 0;
   int errors = 0;
   bit done = 1'b0;
   string phase = "R7";

   // reference model: sample history and expected outputs
   int    hist [$];
   int    ecount = 0;
   longint exp_y [3] = '{0, 0, 0};
   bit    exp_v [3] = '{0, 0, 0};

   function automatic int href(int n, int anti, int t);
      int half = (n + 1) / 2;
      int k   = (t < half) ? t : n - 1 - t;
      int sgn = (t < half) ? 1 : (anti != 0 ? -1 : 1);
      if (anti != 0 && (n % 2) == 1 && k == half - 1) return 0;
      return sgn * CV[k];
   endfunction

   function automatic longint conv(int n, int anti, int idx);
      longint acc = 0;
      for (int t = 0; t < n; t++) begin
         if (idx - t >= 0) acc += longint'(href(n, anti, t)) * longint'(hist[idx - t]);
      end
      return acc;
   endfunction

   always @(posedge clk) begin
      if (rst) begin
         hist.delete();
         ecount = 0;
         for (int i = 0; i < 3; i++) begin exp_y[i] = 0; exp_v[i] = 0; end
      end else if (en) begin
         hist.push_back(int'(din));
         ecount++;
         for (int i = 0; i < 3; i++) begin
            int lat = 3 + $clog2((NT[i] + 1) / 2);
            exp_v[i] = (ecount >= lat);
            exp_y[i] = (ecount >= lat) ? conv(NT[i], AN[i], ecount - lat) : 0;
         end
      end else begin
         for (int i = 0; i < 3; i++) exp_v[i] = 0;
      end
   end

   task automatic check(string req, longint act, longint exp);
      checks++;
      if (act != exp) begin
         errors++;
         $display("FAIL %s (%s) actual %0d expected %0d at %0t", req, phase, act, exp, $time);
      end
   endtask

   task automatic compare_all();
      check("R3 y sym7",   longint'(y0), exp_y[0]);
      check("R4 y anti7",  longint'(y1), exp_y[1]);
      check("R9 y sym6",   longint'(y2), exp_y[2]);
      check("R6 valid sym7",  longint'(v0), longint'(exp_v[0]));
      check("R6 valid anti7", longint'(v1), longint'(exp_v[1]));
      check("R6 valid sym6",  longint'(v2), longint'(exp_v[2]));
   endtask

   task automatic step(bit e, int d);
      @(negedge clk);
      compare_all();
      en  = e;
      din = DATA_W'(d);
   endtask

   task automatic impulse(int amp, int gap);
      step(1'b1, amp);
      for (int s = 0; s < 14; s++) begin
         for (int g = 0; g < gap; g++) step(1'b0, 0);
         step(1'b1, 0);
      end
   endtask

   task automatic finish_report();
      if (!done) begin
         done = 1'b1;
         $display("CHECKS %0d ERRORS %0d", checks, errors);
         $finish;
      end
   endtask

   initial begin
      repeat (200000) @(posedge clk);
      errors++;
      $display("FAIL watchdog expired");
      finish_report();
   end

   initial begin
      // R7: enables during reset are ignored; state is zero after it
      phase = "R7";
      for (int i = 0; i < 4; i++) step(1'b1, 1234 + i);
      step(1'b0, 0);
      rst = 1'b0;
      step(1'b0, 0);
      check("R7 reset y", longint'(y0), 0);
      check("R7 reset valid", longint'(v0), 0);

      // R2: unit impulse and most-negative impulse, with gaps
      phase = "R2";
      impulse(1, 2);
      impulse(-2048, 0);
      impulse(5, 1);

      // R8: walking single bit, back-to-back enables
      phase = "R8";
      for (int b = 0; b < DATA_W; b++) impulse(int'($signed(DATA_W'(1) << b)), 0);

      // R5: long extreme runs fill every pair with the worst case
      phase = "R5";
      for (int i = 0; i < 20; i++) step(1'b1, -2048);
      for (int i = 0; i < 20; i++) step(1'b1, 2047);
      for (int i = 0; i < 20; i++) step(1'b1, (i % 2) ? 2047 : -2048);
      for (int i = 0; i < 20; i++) step(1'b1, -2048);

      // R1 / R6: irregular enables with random data
      phase = "R1";
      for (int i = 0; i < 400; i++) step(($urandom % 3) == 0, int'($urandom % 4096) - 2048);

      // R7: reset in mid-stream, then continue
      phase = "R7";
      @(negedge clk);
      rst = 1'b1;
      en  = 1'b1;
      step(1'b1, 777);
      rst = 1'b0;
      step(1'b0, 0);
      check("R7 mid reset y", longint'(y1), 0);
      check("R7 mid reset valid", longint'(v1), 0);
      phase = "R6";
      for (int i = 0; i < 300; i++) step(($urandom % 2) == 0, int'($urandom % 4096) - 2048);
      for (int i = 0; i < 20; i++) step(1'b1, 0);
      step(1'b0, 0);
      finish_report();
   end

endmodule